// File: doc/BRIEF.md
# Mirror-Folded Product Table Multiplier

This block multiplies a 5-bit unsigned operand by a coefficient fixed at elaboration time, without a multiplier array. It relies on the fact that two operands which are two's complements of each other give products that add up to 32 times the coefficient. Only half of each such pair's difference is kept in a 16-entry constant table. Each product is then rebuilt by adding that table word to, or subtracting it from, a constant offset of 16 times the coefficient.

The operand is split into a top bit and a 4-bit low field. The top bit selects the table address and chooses between adding and subtracting. One operand, the top bit set over a zero low field, needs a table word of zero. That word comes from forcing the table output to zero, not from a stored entry. The result is combinational and zero-extended to the output width. The block is meant as a small constant-coefficient stage inside filters and transforms.

Top module: `mirror_fold_mult`

## Requirements
- R1: For every operand value `op_i` in 0..31, `prod_o` equals `op_i` × `COEF`, as an unsigned integer.
- R2: When `op_i[4]` is 1, the table is read at `op_i[3:0]`, where the word stored at address k≥1 is k×`COEF`, and `prod_o` equals 16×`COEF` plus that word. Such an operand therefore never gives a result below 16×`COEF`.
- R3: When `op_i[4]` is 0, the table is read at the 4-bit two's complement of `op_i[3:0]`, and `prod_o` equals 16×`COEF` minus the word. Such an operand always gives a result below 16×`COEF`.
- R4: Table address 0 holds 16×`COEF`, so operand 0 (binary 00000) yields `prod_o` = 0.
- R5: For operand 16 (binary 10000), the table output is forced to zero, so `prod_o` equals exactly 16×`COEF`.
- R6: The block holds no state: `prod_o` follows `op_i` within the same cycle.
- R7: The output bits at positions 15 (`IN_W`+`COEF_W`) and above are always zero.
- R8: For every x in 1..31, the result for x plus the result for 32−x equals 32×`COEF`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 (`IN_W`) | Unsigned operand; bit 4 picks add or subtract and the address form |
| prod_o | output | 16 (`OUT_W`) | Unsigned product op_i × COEF, zero-extended |

## Verification
Every result of this block is due in the same cycle as its operand, because no register lies between `op_i` and `prod_o`. The bench therefore changes the operand just after a rising clock edge. It reads the product at the following falling edge, half a period later, so it never samples while the input is changing. The mirror-sum check drives the two operands of a pair in consecutive cycles and adds the two captured results. A second instance built with the largest coefficient covers the top of the output range.

// File: rtl/fold_mult_pkg.sv
package fold_mult_pkg;

   // Word held at table index idx: index 0 carries the full offset so that
   // the subtract path returns zero; other indices carry idx multiples.
   function automatic longint unsigned fold_word(input int unsigned idx,
                                                 input longint unsigned coef,
                                                 input int unsigned aw);
      if (idx == 0)
         return coef << aw;
      return coef * idx;
   endfunction

   typedef enum logic {FOLD_ADD = 1'b0, FOLD_SUB = 1'b1} fold_op_e;

endpackage

// File: rtl/fold_addr_map.sv
module fold_addr_map #(
   parameter int unsigned AW = 4
) (
   input  logic [AW:0]              op_i,
   output logic [AW-1:0]            addr_o,
   output fold_mult_pkg::fold_op_e  mode_o,
   output logic                     force_zero_o
);
   import fold_mult_pkg::*;

   logic [AW-1:0] low;
   logic          top;

   assign low = op_i[AW-1:0];
   assign top = op_i[AW];

   always_comb begin
      if (top) begin
         addr_o = low;
         mode_o = FOLD_ADD;
      end else begin
         addr_o = (~low) + {{(AW-1){1'b0}}, 1'b1};
         mode_o = FOLD_SUB;
      end
   end

   assign force_zero_o = top & (low == '0);

endmodule

// File: rtl/fold_table.sv
module fold_table #(
   parameter int unsigned AW   = 4,
   parameter int unsigned COEF = 613,
   parameter int unsigned WW   = 14
) (
   input  logic [AW-1:0] addr_i,
   input  logic          force_zero_i,
   output logic [WW-1:0] word_o
);
   import fold_mult_pkg::*;

   localparam int unsigned DEPTH = 1 << AW;

   logic [WW-1:0] rows [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_row
      localparam longint unsigned VAL = fold_word(g, COEF, AW);
      assign rows[g] = VAL[WW-1:0];
   end

   assign word_o = force_zero_i ? '0 : rows[addr_i];

endmodule

// File: rtl/fold_offset_addsub.sv
module fold_offset_addsub #(
   parameter int unsigned AW        = 4,
   parameter int unsigned COEF      = 613,
   parameter int unsigned WW        = 14,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [WW-1:0]            word_i,
   input  fold_mult_pkg::fold_op_e  mode_i,
   output logic [WW:0]              sum_o
);
   import fold_mult_pkg::*;

   localparam longint unsigned HALF_L = longint'(COEF) << AW;
   localparam logic [WW:0]     HALF   = HALF_L[WW:0];

   logic [WW:0] word_x;
   assign word_x = {1'b0, word_i};

   if (SHARED_ADDER) begin : g_shared
      logic          sub;
      logic [WW:0]   operand;
      assign sub     = (mode_i == FOLD_SUB);
      assign operand = sub ? ~word_x : word_x;
      assign sum_o   = HALF + operand + {{WW{1'b0}}, sub};
   end else begin : g_split
      logic [WW:0] plus_v;
      logic [WW:0] minus_v;
      assign plus_v  = HALF + word_x;
      assign minus_v = HALF - word_x;
      assign sum_o   = (mode_i == FOLD_SUB) ? minus_v : plus_v;
   end

endmodule

// File: rtl/mirror_fold_mult.sv
module mirror_fold_mult #(
   parameter int unsigned IN_W         = 5,
   parameter int unsigned COEF_W       = 10,
   parameter int unsigned COEF         = 613,
   parameter int unsigned OUT_W        = 16,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [IN_W-1:0]  op_i,
   output logic [OUT_W-1:0] prod_o
);
   import fold_mult_pkg::*;

   localparam int unsigned AW = IN_W - 1;
   localparam int unsigned WW = COEF_W + AW;

   if (IN_W < 2) begin : g_chk_in
      $error("mirror_fold_mult: IN_W must be at least 2");
   end
   if (OUT_W < IN_W + COEF_W) begin : g_chk_out
      $error("mirror_fold_mult: OUT_W too narrow for the full product");
   end
   if (longint'(COEF) >= (longint'(1) << COEF_W)) begin : g_chk_coef
      $error("mirror_fold_mult: COEF does not fit in COEF_W bits");
   end

   logic [AW-1:0] tbl_addr;
   fold_op_e      tbl_mode;
   logic          tbl_force;
   logic [WW-1:0] tbl_word;
   logic [WW:0]   sum;

   fold_addr_map #(.AW(AW)) u_map (
      .op_i         (op_i),
      .addr_o       (tbl_addr),
      .mode_o       (tbl_mode),
      .force_zero_o (tbl_force)
   );

   fold_table #(.AW(AW), .COEF(COEF), .WW(WW)) u_table (
      .addr_i       (tbl_addr),
      .force_zero_i (tbl_force),
      .word_o       (tbl_word)
   );

   fold_offset_addsub #(.AW(AW), .COEF(COEF), .WW(WW),
                        .SHARED_ADDER(SHARED_ADDER)) u_addsub (
      .word_i (tbl_word),
      .mode_i (tbl_mode),
      .sum_o  (sum)
   );

   assign prod_o = {{(OUT_W-WW-1){1'b0}}, sum};

endmodule

// File: rtl/fold_mult_chk.sv
module fold_mult_chk #(
   parameter int unsigned IN_W   = 5,
   parameter int unsigned COEF_W = 10,
   parameter int unsigned COEF   = 613,
   parameter int unsigned OUT_W  = 16,
   parameter int unsigned WW     = 14
) (
   input logic [IN_W-1:0]  op_i,
   input logic [OUT_W-1:0] prod_o,
   input logic             force_zero,
   input logic [WW-1:0]    word
);
   localparam longint unsigned HALF_L = longint'(COEF) << (IN_W - 1);
   localparam logic [OUT_W-1:0] HALF  = HALF_L[OUT_W-1:0];
   localparam logic [IN_W-1:0]  MID   = {1'b1, {(IN_W-1){1'b0}}};

   always_comb begin
      if (op_i == '0)
         AST_ZERO_OPERAND: assert (prod_o == '0); // R4
      if (op_i == MID)
         AST_MID_OPERAND: assert (prod_o == HALF); // R5
      if (force_zero)
         AST_FORCED_WORD: assert (word == '0); // R5
      if (op_i[IN_W-1])
         AST_UPPER_HALF: assert (prod_o >= HALF); // R2
      if (!op_i[IN_W-1])
         AST_LOWER_HALF: assert (prod_o < HALF); // R3
      AST_HIGH_BITS_ZERO: assert ((prod_o >> (IN_W + COEF_W)) == '0); // R7
   end
endmodule

bind mirror_fold_mult fold_mult_chk #(
   .IN_W(IN_W), .COEF_W(COEF_W), .COEF(COEF), .OUT_W(OUT_W), .WW(WW)
) u_chk (
   .op_i       (op_i),
   .prod_o     (prod_o),
   .force_zero (tbl_force),
   .word       (tbl_word)
);

// File: tb/mirror_fold_mult_tb.sv
module mirror_fold_mult_tb;
   localparam int unsigned IN_W   = 5;
   localparam int unsigned COEF_W = 10;
   localparam int unsigned COEF   = 613;
   localparam int unsigned CMAX   = 1023;
   localparam int unsigned OUT_W  = 16;

   logic             clk = 1'b0;
   logic [IN_W-1:0]  op = '0;
   logic [OUT_W-1:0] prod;
   logic [OUT_W-1:0] prod_max;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;
   bit          done    = 1'b0;

   always #5 clk = ~clk;

   mirror_fold_mult #(.IN_W(IN_W), .COEF_W(COEF_W), .COEF(COEF), .OUT_W(OUT_W))
      u_dut (.op_i(op), .prod_o(prod));

   mirror_fold_mult #(.IN_W(IN_W), .COEF_W(COEF_W), .COEF(CMAX), .OUT_W(OUT_W),
                      .SHARED_ADDER(1'b0))
      u_dut_max (.op_i(op), .prod_o(prod_max));

   function automatic int unsigned exp_prod(input int unsigned b, input int unsigned c);
      return b * c;
   endfunction

   task automatic check(input string req, input int unsigned act, input int unsigned exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s op=%0d actual=%0d expected=%0d", req, op, act, exp);
      end
   endtask

   task automatic apply(input int unsigned v);
      @(posedge clk);
      op = v[IN_W-1:0];
      @(negedge clk);
   endtask

   initial begin
      int unsigned seed_set;
      int unsigned first;
      seed_set = $urandom(32'd1357);
      @(negedge clk);
      // R6: no state, result present at first sample
      check("R6 initial", prod, 0);

      // R4 and R5 corners
      apply(0);
      check("R4 zero operand", prod, 0);
      check("R4 zero operand max coef", prod_max, 0);
      apply(16);
      check("R5 mid operand", prod, 16 * COEF);
      check("R5 mid operand max coef", prod_max, 16 * CMAX);
      apply(31);
      check("R7 top bits at max", prod_max >> 15, 0);
      check("R1 max operand max coef", prod_max, 31 * CMAX);

      // R1, R2, R3 exhaustive sweep
      for (int v = 0; v < 32; v++) begin
         apply(v);
         if (v >= 16) check("R2 upper half", prod, exp_prod(v, COEF));
         else         check("R3 lower half", prod, exp_prod(v, COEF));
         check("R1 max coef", prod_max, exp_prod(v, CMAX));
      end

      // R6: random operands, each result due in the same cycle
      for (int i = 0; i < 200; i++) begin
         int unsigned r;
         r = $urandom % 32;
         apply(r);
         check("R6 random", prod, exp_prod(r, COEF));
         check("R1 random max coef", prod_max, exp_prod(r, CMAX));
      end

      // R8 mirror sum
      for (int x = 1; x < 32; x++) begin
         apply(x);
         first = prod;
         apply(32 - x);
         check("R8 mirror sum", first + prod, 32 * COEF);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule